// File: doc/BRIEF.md
# Ring Buffer Drain Controller

This block drains a circular buffer held in memory on behalf of one DMA channel. The ring is described by a base address and a size mask. A separate producer fills the ring and publishes its current write address. For each command the controller receives the channel's drain address, its tag address and the number of quadwords still owed. It works out how many quadwords sit between the drain address and the producer address, clamps the request to that amount, and issues one or two read bursts. When the data would run past the top of the ring, it splits the read into a burst that ends at the top and a burst that starts again at the base.

When the transfer is finished, the drain and tag addresses are folded back into the ring. The controller reports the new addresses and the quadwords still owed. If the ring holds no data, it raises an empty flag and issues no read. A data address that points outside the ring is read straight through, with no occupancy test. When a fresh tag has just been decoded, the tag's kind decides whether an out-of-range data address is first pulled back into the ring.

A command is taken only while the block is idle. Each burst is offered as a start address and a quadword count. Memory answers with an acknowledge that carries the number of quadwords it actually took.

Top module: `ring_drain_ctrl`

## Requirements
- R1: When the drain address is less than or equal to the producer address, the available quadword count is (producer − drain) / 16.
- R2: When the drain address is above the producer address, the available count is ((producer − base) + (base + mask + 16 − drain)) / 16.
- R3: With an in-ring drain address and zero quadwords available, `empty_o` is high at completion, no burst is requested, and the drain address, tag address and owed count are returned unchanged.
- R4: The quadwords moved from the ring are min(available, requested). `left_o` equals the request minus the sum of the accepted counts reported by memory.
- R5: Let the room before the top be (base + mask + 16 − drain) / 16. When the transfer exceeds the room, the first burst starts at the drain address with a count equal to the room. The second burst starts at the base with the remainder. Otherwise a single burst is issued.
- R6: The second burst of a split is requested only if memory accepted the whole first burst.
- R7: After an in-ring transfer, `drain_o` and `tag_o` are each base + (address AND mask), where the drain address has advanced 16 bytes per accepted quadword.
- R8: When `new_tag_i` is set and `kind_i` is one of the inline-data kinds (1 count, 2 next, 5 call, 6 return, 7 end), a drain address below the base or above base + mask is first replaced by base + (address AND mask). Kinds 0, 3 and 4, or a clear `new_tag_i`, leave it unchanged.
- R9: A drain address whose bits outside the mask differ from the base is read in one burst of the full requested count. There is no occupancy check, `empty_o` stays low, and neither address is wrapped: `drain_o` is the drain address plus 16 times the accepted count, and `tag_o` is the tag input.
- R10: While `rd_req_o` is high and not acknowledged, the request, its address and its count stay stable. The count is never zero.
- R11: A requested count of zero completes with no burst, `left_o` = 0, and both addresses unchanged.
- R12: `done_o` is a one-cycle pulse while `busy_o` is high. `busy_o` falls in the next cycle, and a start pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Accept a command (idle only) |
| base_i | input | AW | Ring base address |
| mask_i | input | AW | Ring size mask (2^n − 16) |
| prod_i | input | AW | Producer write address |
| drain_i | input | AW | Channel data (drain) address |
| tag_i | input | AW | Channel tag address |
| qwc_i | input | CW | Quadwords requested |
| kind_i | input | 3 | Kind of the tag just decoded |
| new_tag_i | input | 1 | A tag was decoded for this command |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | Completion pulse |
| empty_o | output | 1 | Ring held no data for the last command |
| drain_o | output | AW | Updated drain address |
| tag_o | output | AW | Updated tag address |
| left_o | output | CW | Quadwords still owed |
| rd_req_o | output | 1 | Burst request |
| rd_addr_o | output | AW | Burst start address |
| rd_qwc_o | output | CW | Burst quadword count |
| rd_ack_i | input | 1 | Burst acknowledge |
| rd_acc_i | input | CW | Quadwords accepted by memory |

## Verification
The bench keeps the 32-bit address width and narrows the count width to 10 bits. It uses a 16-quadword ring at 0x1000, so wrap-around, a drain address exactly one quadword below the top, and split bursts all occur with short requests. Memory in the bench takes a per-command acceptance limit, which brings a short first burst, and so the suppressed second burst, within reach. Out-of-ring addresses above the ring exercise both the direct read and the kind-dependent repair.

// File: rtl/ring_drain_pkg.sv
package ring_drain_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EVAL,
        ST_BURST1,
        ST_BURST2,
        ST_DONE
    } drain_state_e;

    typedef enum logic [2:0] {
        TK_REF_END   = 3'd0,
        TK_COUNT     = 3'd1,
        TK_NEXT      = 3'd2,
        TK_REF       = 3'd3,
        TK_REF_STALL = 3'd4,
        TK_CALL      = 3'd5,
        TK_RETURN    = 3'd6,
        TK_END       = 3'd7
    } tag_kind_e;

    // Kinds whose payload follows the tag and so lives inside the ring
    function automatic logic kind_has_inline_data(input logic [2:0] kind);
        case (kind)
            TK_COUNT, TK_NEXT, TK_CALL, TK_RETURN, TK_END: return 1'b1;
            default:                                       return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/ring_occupancy.sv
module ring_occupancy #(
    parameter int AW       = 32,
    parameter int QW_BYTES = 16
) (
    input  logic [AW-1:0] base_i,
    input  logic [AW-1:0] mask_i,
    input  logic [AW-1:0] prod_i,
    input  logic [AW-1:0] drain_i,
    output logic          in_ring_o,
    output logic [AW-1:0] avail_o,
    output logic [AW-1:0] room_o
);
    localparam int QSH = $clog2(QW_BYTES);

    logic [AW-1:0] top;
    logic [AW-1:0] span;

    always_comb begin
        top       = base_i + mask_i + AW'(QW_BYTES);
        in_ring_o = ((drain_i & ~mask_i) == base_i);
        if (drain_i <= prod_i) begin
            span = prod_i - drain_i;
        end else begin
            span = (prod_i - base_i) + (top - drain_i);
        end
        avail_o = span >> QSH;
        room_o  = (top - drain_i) >> QSH;
    end

endmodule

// File: rtl/ring_tag_fixup.sv
module ring_tag_fixup
    import ring_drain_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          new_tag_i,
    input  logic [2:0]    kind_i,
    input  logic [AW-1:0] base_i,
    input  logic [AW-1:0] mask_i,
    input  logic [AW-1:0] addr_i,
    output logic [AW-1:0] addr_o
);
    logic [AW-1:0] last;
    logic          outside;
    logic          repair;

    always_comb begin
        last    = base_i + mask_i;
        outside = (addr_i < base_i) || (addr_i > last);
        repair  = new_tag_i && kind_has_inline_data(kind_i) && outside;
        addr_o  = repair ? (base_i + (addr_i & mask_i)) : addr_i;
    end

endmodule

// File: rtl/ring_drain_ctrl.sv
module ring_drain_ctrl
    import ring_drain_pkg::*;
#(
    parameter int AW       = 32,
    parameter int CW       = 16,
    parameter int QW_BYTES = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [AW-1:0] base_i,
    input  logic [AW-1:0] mask_i,
    input  logic [AW-1:0] prod_i,
    input  logic [AW-1:0] drain_i,
    input  logic [AW-1:0] tag_i,
    input  logic [CW-1:0] qwc_i,
    input  logic [2:0]    kind_i,
    input  logic          new_tag_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          empty_o,
    output logic [AW-1:0] drain_o,
    output logic [AW-1:0] tag_o,
    output logic [CW-1:0] left_o,
    output logic          rd_req_o,
    output logic [AW-1:0] rd_addr_o,
    output logic [CW-1:0] rd_qwc_o,
    input  logic          rd_ack_i,
    input  logic [CW-1:0] rd_acc_i
);
    localparam int QSH = $clog2(QW_BYTES);

    typedef struct packed {
        drain_state_e  st;
        logic [AW-1:0] base;
        logic [AW-1:0] mask;
        logic [AW-1:0] prod;
        logic [AW-1:0] drain;
        logic [AW-1:0] tag;
        logic [CW-1:0] left;
        logic [CW-1:0] first;
        logic [CW-1:0] second;
        logic          split;
        logic          direct;
        logic          empty;
    } drain_regs_t;

    drain_regs_t r_d, r_q;

    logic          occ_in_ring;
    logic [AW-1:0] occ_avail;
    logic [AW-1:0] occ_room;
    logic [AW-1:0] fixed_drain;
    logic [AW-1:0] ring_base_q;

    ring_occupancy #(.AW(AW), .QW_BYTES(QW_BYTES)) u_occ (
        .base_i   (r_q.base),
        .mask_i   (r_q.mask),
        .prod_i   (r_q.prod),
        .drain_i  (r_q.drain),
        .in_ring_o(occ_in_ring),
        .avail_o  (occ_avail),
        .room_o   (occ_room)
    );

    ring_tag_fixup #(.AW(AW)) u_fix (
        .new_tag_i(new_tag_i),
        .kind_i   (kind_i),
        .base_i   (base_i),
        .mask_i   (mask_i),
        .addr_i   (drain_i),
        .addr_o   (fixed_drain)
    );

    function automatic logic [AW-1:0] fold(input logic [AW-1:0] a,
                                           input logic [AW-1:0] b,
                                           input logic [AW-1:0] m);
        return b + (a & m);
    endfunction

    logic [CW-1:0] cur_cnt;
    logic [CW-1:0] acc_eff;
    logic [AW-1:0] moved;
    logic [AW-1:0] xfer_w;

    always_comb begin
        r_d     = r_q;
        cur_cnt = (r_q.st == ST_BURST2) ? r_q.second : r_q.first;
        acc_eff = (rd_acc_i > cur_cnt) ? cur_cnt : rd_acc_i;
        moved   = r_q.drain + (AW'(acc_eff) << QSH);
        xfer_w  = (occ_avail < AW'(r_q.left)) ? occ_avail : AW'(r_q.left);

        case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.st     = ST_EVAL;
                    r_d.base   = base_i;
                    r_d.mask   = mask_i;
                    r_d.prod   = prod_i;
                    r_d.drain  = fixed_drain;
                    r_d.tag    = tag_i;
                    r_d.left   = qwc_i;
                    r_d.first  = '0;
                    r_d.second = '0;
                    r_d.split  = 1'b0;
                    r_d.direct = 1'b0;
                    r_d.empty  = 1'b0;
                end
            end
            ST_EVAL: begin
                if (r_q.left == '0) begin
                    r_d.st = ST_DONE;
                end else if (!occ_in_ring) begin
                    r_d.st     = ST_BURST1;
                    r_d.direct = 1'b1;
                    r_d.first  = r_q.left;
                end else if (occ_avail == '0) begin
                    r_d.st    = ST_DONE;
                    r_d.empty = 1'b1;
                end else if (xfer_w > occ_room) begin
                    r_d.st     = ST_BURST1;
                    r_d.split  = 1'b1;
                    r_d.first  = CW'(occ_room);
                    r_d.second = CW'(xfer_w - occ_room);
                end else begin
                    r_d.st    = ST_BURST1;
                    r_d.first = CW'(xfer_w);
                end
            end
            ST_BURST1: begin
                if (rd_ack_i) begin
                    r_d.left = r_q.left - acc_eff;
                    if (r_q.split && (acc_eff == r_q.first)) begin
                        r_d.st    = ST_BURST2;
                        r_d.drain = r_q.base;
                    end else begin
                        r_d.st = ST_DONE;
                        if (r_q.direct) begin
                            r_d.drain = moved;
                        end else begin
                            r_d.drain = fold(moved, r_q.base, r_q.mask);
                            r_d.tag   = fold(r_q.tag, r_q.base, r_q.mask);
                        end
                    end
                end
            end
            ST_BURST2: begin
                if (rd_ack_i) begin
                    r_d.st    = ST_DONE;
                    r_d.left  = r_q.left - acc_eff;
                    r_d.drain = fold(moved, r_q.base, r_q.mask);
                    r_d.tag   = fold(r_q.tag, r_q.base, r_q.mask);
                end
            end
            ST_DONE: begin
                r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign ring_base_q = r_q.base;
    assign busy_o      = (r_q.st != ST_IDLE);
    assign done_o      = (r_q.st == ST_DONE);
    assign empty_o     = r_q.empty;
    assign drain_o     = r_q.drain;
    assign tag_o       = r_q.tag;
    assign left_o      = r_q.left;
    assign rd_req_o    = (r_q.st == ST_BURST1) || (r_q.st == ST_BURST2);
    assign rd_addr_o   = r_q.drain;
    assign rd_qwc_o    = cur_cnt;

endmodule

module ring_drain_chk #(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy_o,
    input logic          done_o,
    input logic          empty_o,
    input logic          rd_req_o,
    input logic [AW-1:0] rd_addr_o,
    input logic [CW-1:0] rd_qwc_o,
    input logic          rd_ack_i,
    input logic [CW-1:0] rd_acc_i,
    input logic [AW-1:0] ring_base_q
);
    // R10: an unanswered request holds still
    assert_req_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && !rd_ack_i) |=> (rd_req_o && $stable(rd_addr_o) && $stable(rd_qwc_o)));

    assert_req_nonzero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |-> (rd_qwc_o != '0));

    // R12: completion is a single-cycle pulse inside busy
    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o);

    // R3: an empty ring never leads to a read
    assert_empty_noburst_R3: assert property (@(posedge clk) disable iff (!rst_n)
        empty_o |-> !rd_req_o);

    // R5: a request directly after an acknowledged one restarts at the base
    assert_second_at_base_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && $past(rd_req_o) && $past(rd_ack_i)) |-> (rd_addr_o == ring_base_q));

    // R6: the second burst only follows a fully accepted first burst
    assert_second_after_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && $past(rd_req_o) && $past(rd_ack_i)) |-> ($past(rd_acc_i) >= $past(rd_qwc_o)));

endmodule

bind ring_drain_ctrl ring_drain_chk #(.AW(AW), .CW(CW)) u_ring_drain_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .empty_o    (empty_o),
    .rd_req_o   (rd_req_o),
    .rd_addr_o  (rd_addr_o),
    .rd_qwc_o   (rd_qwc_o),
    .rd_ack_i   (rd_ack_i),
    .rd_acc_i   (rd_acc_i),
    .ring_base_q(ring_base_q)
);

// File: tb/ring_drain_ctrl_bench.sv
module ring_drain_ctrl_bench;
    localparam int AW = 32;
    localparam int CW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [AW-1:0] base_i = '0, mask_i = '0, prod_i = '0, drain_i = '0, tag_i = '0;
    logic [CW-1:0] qwc_i = '0;
    logic [2:0]    kind_i = '0;
    logic          new_tag_i = 1'b0;
    logic          busy_o, done_o, empty_o, rd_req_o;
    logic [AW-1:0] drain_o, tag_o, rd_addr_o;
    logic [CW-1:0] left_o, rd_qwc_o;
    logic          rd_ack_i = 1'b0;
    logic [CW-1:0] rd_acc_i = '0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    ring_drain_ctrl #(.AW(AW), .CW(CW)) u_ring_drain_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .base_i(base_i), .mask_i(mask_i), .prod_i(prod_i),
        .drain_i(drain_i), .tag_i(tag_i), .qwc_i(qwc_i),
        .kind_i(kind_i), .new_tag_i(new_tag_i),
        .busy_o(busy_o), .done_o(done_o), .empty_o(empty_o),
        .drain_o(drain_o), .tag_o(tag_o), .left_o(left_o),
        .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_qwc_o(rd_qwc_o),
        .rd_ack_i(rd_ack_i), .rd_acc_i(rd_acc_i)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 100000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Behavioural expectation of one command
    longint ex_addr[2];
    longint ex_cnt[2];
    int     ex_n;
    longint ex_drain, ex_tag, ex_left;
    bit     ex_empty;

    function automatic longint lmin(input longint a, input longint b);
        return (a < b) ? a : b;
    endfunction

    task automatic model(input longint base, input longint mask, input longint prod,
                         input longint drain, input longint tag, input longint qwc,
                         input int kind, input bit nt, input longint lim);
        longint d, top, avail, x, room, a0, a1, fin;
        bit inline_k;
        inline_k = (kind == 1) || (kind == 2) || (kind == 5) || (kind == 6) || (kind == 7);
        d = drain;
        if (nt && inline_k && (d < base || d > base + mask)) d = base + (d & mask);
        ex_n = 0; ex_empty = 0; ex_left = qwc; ex_tag = tag; ex_drain = d;
        if (qwc == 0) return;
        if ((d & ~mask & 64'hFFFF_FFFF) != base) begin
            ex_addr[0] = d; ex_cnt[0] = qwc; ex_n = 1;
            a0 = lmin(qwc, lim);
            ex_left = qwc - a0;
            ex_drain = d + a0 * 16;
            return;
        end
        top = base + mask + 16;
        avail = (d <= prod) ? (prod - d) / 16 : ((prod - base) + (top - d)) / 16;
        if (avail == 0) begin
            ex_empty = 1;
            return;
        end
        x = lmin(avail, qwc);
        room = (top - d) / 16;
        if (x > room) begin
            ex_addr[0] = d; ex_cnt[0] = room;
            a0 = lmin(room, lim);
            ex_n = 1;
            ex_left = qwc - a0;
            if (a0 == room) begin
                ex_addr[1] = base; ex_cnt[1] = x - room; ex_n = 2;
                a1 = lmin(x - room, lim);
                ex_left = ex_left - a1;
                fin = base + a1 * 16;
            end else begin
                fin = d + a0 * 16;
            end
        end else begin
            ex_addr[0] = d; ex_cnt[0] = x; ex_n = 1;
            a0 = lmin(x, lim);
            ex_left = qwc - a0;
            fin = d + a0 * 16;
        end
        ex_drain = base + (fin & mask);
        ex_tag = base + (tag & mask);
    endtask

    task automatic run_op(input string req, input longint base, input longint mask,
                          input longint prod, input longint drain, input longint tag,
                          input longint qwc, input int kind, input bit nt,
                          input longint lim, input bit poke);
        int idx, waits;
        bit finished, poked;
        model(base, mask, prod, drain, tag, qwc, kind, nt, lim);
        @(negedge clk);
        base_i = AW'(base); mask_i = AW'(mask); prod_i = AW'(prod);
        drain_i = AW'(drain); tag_i = AW'(tag); qwc_i = CW'(qwc);
        kind_i = 3'(kind); new_tag_i = nt; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o == 1'b1, "R12", "busy after start", busy_o, 1);
        idx = 0; waits = -1; finished = 0; poked = 0;
        for (int cyc = 0; cyc < 200 && !finished; cyc++) begin
            if (!busy_o) begin
                check(0, "R12", "busy dropped before done", 0, 1);
                finished = 1;
            end
            if (rd_req_o && !finished) begin
                if (waits < 0) begin
                    if (idx >= ex_n) begin
                        check(0, req, "unexpected burst address", rd_addr_o, 0);
                    end else begin
                        check(rd_addr_o == AW'(ex_addr[idx]), req, "burst address", rd_addr_o, ex_addr[idx]);
                        check(rd_qwc_o == CW'(ex_cnt[idx]), req, "burst count", rd_qwc_o, ex_cnt[idx]);
                    end
                    if (poke && !poked) begin
                        start_i = 1'b1; drain_i = 32'h0000_5000; qwc_i = CW'(3); poked = 1;
                    end
                    waits = 1;
                end else if (waits > 0) begin
                    waits = waits - 1;
                end else begin
                    rd_ack_i = 1'b1;
                    rd_acc_i = CW'(lmin(longint'(rd_qwc_o), lim));
                    idx = idx + 1;
                    waits = -1;
                end
            end
            if (done_o && !finished) begin
                check(idx == ex_n, req, "burst count per command", idx, ex_n);
                check(drain_o == AW'(ex_drain), req, "drain result", drain_o, ex_drain);
                check(tag_o == AW'(ex_tag), req, "tag result", tag_o, ex_tag);
                check(left_o == CW'(ex_left), req, "owed quadwords", left_o, ex_left);
                check(empty_o == ex_empty, req, "empty flag", empty_o, ex_empty);
                finished = 1;
            end
            @(negedge clk);
            rd_ack_i = 1'b0;
            start_i = 1'b0;
        end
        if (!finished) check(0, req, "command never completed", 0, 1);
        check(done_o == 1'b0 && busy_o == 1'b0, "R12", "done pulse and busy release",
              {done_o, busy_o}, 0);
        check(rd_req_o == 1'b0, "R12", "no request after completion (ignored start)", rd_req_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(busy_o == 0 && done_o == 0 && empty_o == 0 && rd_req_o == 0, "R12",
              "reset state", {busy_o, done_o, empty_o, rd_req_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // ring: base 0x1000, mask 0xF0 (16 quadwords), top 0x1100
        // R1: drain below producer, request larger than available (R4)
        run_op("R1", 'h1000, 'hF0, 'h1080, 'h1020, 'h1234, 10, 0, 0, 1000, 0);
        // R4: request smaller than available
        run_op("R4", 'h1000, 'hF0, 'h10E0, 'h1000, 'h1010, 3, 0, 0, 1000, 0);
        // R2 + R5: producer wrapped, split at the top
        run_op("R2", 'h1000, 'hF0, 'h1040, 'h10C0, 'h1000, 20, 0, 0, 1000, 0);
        // R5: drain one quadword below the top
        run_op("R5", 'h1000, 'hF0, 'h1010, 'h10F0, 'h10F0, 4, 0, 0, 1000, 0);
        // R6: first burst only partly accepted, no second burst
        run_op("R6", 'h1000, 'hF0, 'h1040, 'h10C0, 'h1000, 20, 0, 0, 3, 0);
        // R7: partial accept on a single burst, folding of addresses
        run_op("R7", 'h1000, 'hF0, 'h10A0, 'h1050, 'h1FF0, 5, 0, 0, 2, 0);
        // R3: drain equals producer, nothing available
        run_op("R3", 'h1000, 'hF0, 'h1060, 'h1060, 'h1020, 7, 0, 0, 1000, 0);
        // R9: direct read outside the ring
        run_op("R9", 'h1000, 'hF0, 'h1060, 'h8000, 'h1020, 5, 0, 0, 1000, 0);
        // R8: inline kind (1) repairs an address above the ring
        run_op("R8", 'h1000, 'hF0, 'h1090, 'h1150, 'h1040, 2, 1, 1, 1000, 0);
        // R8: return kind (6) repairs an address below the ring
        run_op("R8", 'h1000, 'hF0, 'h10B0, 'h0F30, 'h1040, 4, 6, 1, 1000, 0);
        // R8: reference kind (3) leaves it outside -> direct read
        run_op("R8", 'h1000, 'hF0, 'h1090, 'h1150, 'h1040, 2, 3, 1, 1000, 0);
        // R8: inline kind without a fresh tag leaves it outside
        run_op("R8", 'h1000, 'hF0, 'h1090, 'h1150, 'h1040, 2, 2, 0, 1000, 0);
        // R11: zero request
        run_op("R11", 'h1000, 'hF0, 'h1090, 'h1020, 'h1040, 0, 0, 0, 1000, 0);
        // R12 / R10: start pulsed while busy must be ignored
        run_op("R12", 'h1000, 'hF0, 'h1040, 'h10C0, 'h1000, 20, 0, 0, 1000, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule